// File: doc/BRIEF.md
# Power-Mode Event Arbiter

This block sits beside a small microcontroller core. It decides what each incoming event does, given the power mode the core is in. There are three modes: sleep, green and normal. In green mode the core runs from a 32768 Hz clock. In normal mode it runs from a PLL-multiplied high-frequency clock.

The event sources are three timer timeouts, a watchdog timeout, four port pins, a data-detect pin with selectable edge polarity, and a stack-overflow pulse. For each event the block produces one of three actions:

- ignore it;
- request an interrupt to vector 8;
- request a restart at address 0.

Port pins and the data-detect pin are synchronised and edge-detected inside the block. Timer, watchdog and overflow inputs are single-cycle pulses that are already in the clock domain. Each interrupt source owns a sticky pending flag, which the CPU clears by writing one to it. An event accepted while asleep also produces a one-cycle wake pulse, which the clock controller uses to restart the oscillator.

A three-state machine drives the request outputs:

- `ST_IDLE`: nothing is pending.
- `ST_IRQ`: at least one pending flag is set, and the interrupt request is held.
- `ST_RESET`: one cycle in which the restart request is asserted and all pending flags are zero.

Every state is reached the same way. A restart-class event moves the machine to `ST_RESET`. Otherwise it goes to `ST_IRQ` if the next pending vector is non-zero, and to `ST_IDLE` if it is zero. Leaving `ST_RESET` follows the same rule on the following cycle.

Top module: `pwr_event_arbiter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `pend`, `irq_req`, `rst_req`, `wake` are 0 and `act_code` is 2'b00. `act_code` encodes the action as 2'b00 = none, 2'b01 = interrupt to vector 8, and 2'b10 = restart at address 0.
- R2: In green (`pwr_mode` 2'b01) or normal (2'b10 or 2'b11) mode, a pulse on `tmr_to[i]` with `tmr_en[i]` and `gie` set does three things on the next clock edge: it sets `pend[i]` (bit 0 = timer 0, bit 1 = counter 1, bit 2 = counter 2), sets `act_code` to 2'b01, and raises `irq_req`.
- R3: Timer, data-detect and stack-overflow events have no effect in sleep mode (`pwr_mode` 2'b00). They also have no effect in any mode when `gie` or the source's own enable is clear. In these cases `pend`, `act_code` and `rst_req` stay unchanged or zero.
- R4: A `wdt_to` pulse produces `act_code` 2'b10 and `rst_req` on the next edge, in every mode, whatever the enables are.
- R5: A falling edge on any `port_pin` bit counts as an event only when `gie` and at least one `port_en` bit are set. In sleep mode the event produces a restart (2'b10). In green or normal mode it sets `pend[3]` and produces an interrupt (2'b01). The result appears three edges after the pin changes. Rising edges are ignored.
- R6: The data-detect pin reacts to a rising edge when `dd_edge_rise` is 1 and to a falling edge when it is 0. With `dd_en` and `gie` set, outside sleep, the selected edge sets `pend[4]` three edges after the pin changes. The other edge does nothing.
- R7: A `stk_ovf` pulse with `ovf_en` and `gie` set, outside sleep, sets `pend[5]` with `act_code` 2'b01 on the next edge.
- R8: When a restart event and an interrupt event arrive in the same cycle, the restart wins: `act_code` is 2'b10 and every pending flag is cleared.
- R9: Writing one to `pend_clr[i]` clears `pend[i]` on the next edge and leaves the other flags alone. If a new event for source i arrives in the same cycle as the clear, the flag stays set.
- R10: `wake` pulses high for exactly one cycle, together with the action, when an event is accepted in sleep mode. It stays low for events accepted in green or normal mode.
- R11: `irq_req` is high exactly while `pend` is non-zero. It falls on the same edge that clears the last pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_mode | input | 2 | 00 sleep, 01 green, 10/11 normal |
| gie | input | 1 | Global interrupt enable |
| tmr_en | input | 3 | Per-timer enables (control bits 0..2) |
| port_en | input | 3 | Port-change enables (control bits 3..5), any one suffices |
| dd_en | input | 1 | Data-detect enable |
| ovf_en | input | 1 | Stack-overflow enable |
| dd_edge_rise | input | 1 | 1 = data-detect on rising edge, 0 = on falling edge |
| tmr_to | input | 3 | Timer/counter timeout pulses |
| wdt_to | input | 1 | Watchdog timeout pulse |
| port_pin | input | 4 | Asynchronous port pins, idle high |
| dd_pin | input | 1 | Asynchronous data-detect pin |
| stk_ovf | input | 1 | Stack-overflow pulse |
| pend_clr | input | 6 | Write-one-to-clear strobes for the pending flags |
| pend | output | 6 | Pending flags: timers 0..2, port, data-detect, overflow |
| irq_req | output | 1 | Interrupt request to vector 8 |
| rst_req | output | 1 | Restart request to address 0 |
| act_code | output | 2 | Action taken this cycle |
| wake | output | 1 | One-cycle oscillator restart pulse |

## Verification
The assertions check the following on every cycle:

- the two request outputs are never active together;
- a watchdog pulse is always followed by a restart;
- a restart leaves no pending flag set;
- no pending flag ever rises while the mode is sleep;
- a wake pulse only follows a sleep-mode cycle and always comes with a restart;
- the edge detector never emits back-to-back pulses while its polarity is steady.

Some behaviour only the bench scenarios can show. The sweep covers every mode, global-enable value, per-source enable and source, and checks the exact action, pending vector and wake value against arithmetic expectations. Directed cases cover:

- the three-edge pin latency;
- rejection of the unselected edge;
- restart winning over a simultaneous interrupt;
- a set colliding with a clear;
- the request dropping when the last flag is cleared.

// File: rtl/pwr_evt_pkg.sv
package pwr_evt_pkg;

    typedef enum logic [1:0] {
        PM_SLEEP  = 2'b00,
        PM_GREEN  = 2'b01,
        PM_NORMAL = 2'b10,
        PM_NORM_B = 2'b11
    } pm_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'b00,
        ACT_IRQ   = 2'b01,
        ACT_RESET = 2'b10
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_IRQ   = 2'b01,
        ST_RESET = 2'b10
    } arb_state_e;

    localparam int N_TMR    = 3;
    localparam int SRC_PORT = N_TMR;
    localparam int SRC_DD   = N_TMR + 1;
    localparam int SRC_OVF  = N_TMR + 2;
    localparam int N_SRC    = N_TMR + 3;

endpackage

// File: rtl/pin_edge_det.sv
module pin_edge_det #(
    parameter int   W       = 1,
    parameter int   SYNC    = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         rise_sel,
    output logic [W-1:0] evt
);

    logic [W-1:0] stg [SYNC];
    logic [W-1:0] prev_q;
    logic [W-1:0] cur;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC; s++) stg[s] <= {W{RST_VAL}};
            prev_q <= {W{RST_VAL}};
        end else begin
            stg[0] <= din;
            for (int s = 1; s < SYNC; s++) stg[s] <= stg[s-1];
            prev_q <= stg[SYNC-1];
        end
    end

    assign cur = stg[SYNC-1];

    always_comb begin
        if (rise_sel) evt = cur & ~prev_q;
        else          evt = ~cur & prev_q;
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt != '0) && $stable(rise_sel)) |=> ((evt & $past(evt)) == '0)); // R5

endmodule

// File: rtl/evt_classify.sv
module evt_classify
    import pwr_evt_pkg::*;
#(
    parameter int N_PIN = 4
) (
    input  logic [1:0]       pwr_mode,
    input  logic             gie,
    input  logic [N_TMR-1:0] tmr_en,
    input  logic [2:0]       port_en,
    input  logic             dd_en,
    input  logic             ovf_en,
    input  logic [N_TMR-1:0] tmr_to,
    input  logic             wdt_to,
    input  logic [N_PIN-1:0] port_evt,
    input  logic             dd_evt,
    input  logic             stk_ovf,
    output logic [N_SRC-1:0] irq_set,
    output logic             rst_hit
);

    logic asleep;
    logic port_hit;

    assign asleep   = (pm_e'(pwr_mode) == PM_SLEEP);
    assign port_hit = gie && (port_en != '0) && (port_evt != '0);

    genvar t;
    generate
        for (t = 0; t < N_TMR; t++) begin : g_tmr
            assign irq_set[t] = !asleep && gie && tmr_en[t] && tmr_to[t];
        end
    endgenerate

    assign irq_set[SRC_PORT] = !asleep && port_hit;
    assign irq_set[SRC_DD]   = !asleep && gie && dd_en && dd_evt;
    assign irq_set[SRC_OVF]  = !asleep && gie && ovf_en && stk_ovf;

    assign rst_hit = wdt_to || (asleep && port_hit);

endmodule

// File: rtl/pwr_event_arbiter.sv
module pwr_event_arbiter
    import pwr_evt_pkg::*;
#(
    parameter int N_PIN = 4,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       pwr_mode,
    input  logic             gie,
    input  logic [2:0]       tmr_en,
    input  logic [2:0]       port_en,
    input  logic             dd_en,
    input  logic             ovf_en,
    input  logic             dd_edge_rise,
    input  logic [2:0]       tmr_to,
    input  logic             wdt_to,
    input  logic [N_PIN-1:0] port_pin,
    input  logic             dd_pin,
    input  logic             stk_ovf,
    input  logic [5:0]       pend_clr,
    output logic [5:0]       pend,
    output logic             irq_req,
    output logic             rst_req,
    output logic [1:0]       act_code,
    output logic             wake
);

    logic [N_PIN-1:0] port_evt;
    logic [0:0]       dd_evt;
    logic [N_SRC-1:0] irq_set;
    logic             rst_hit;

    arb_state_e       state_q, state_n;
    logic [N_SRC-1:0] pend_q, pend_n;
    act_e             act_q, act_n;
    logic             wake_q, wake_n;

    pin_edge_det #(.W(N_PIN), .SYNC(SYNC), .RST_VAL(1'b1)) u_port_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (port_pin),
        .rise_sel (1'b0),
        .evt      (port_evt)
    );

    pin_edge_det #(.W(1), .SYNC(SYNC), .RST_VAL(1'b0)) u_dd_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (dd_pin),
        .rise_sel (dd_edge_rise),
        .evt      (dd_evt)
    );

    evt_classify #(.N_PIN(N_PIN)) u_classify (
        .pwr_mode (pwr_mode),
        .gie      (gie),
        .tmr_en   (tmr_en),
        .port_en  (port_en),
        .dd_en    (dd_en),
        .ovf_en   (ovf_en),
        .tmr_to   (tmr_to),
        .wdt_to   (wdt_to),
        .port_evt (port_evt),
        .dd_evt   (dd_evt[0]),
        .stk_ovf  (stk_ovf),
        .irq_set  (irq_set),
        .rst_hit  (rst_hit)
    );

    // Next pending vector and next state
    always_comb begin
        pend_n = (pend_q & ~pend_clr) | irq_set;
        act_n  = ACT_NONE;
        if (rst_hit) begin
            pend_n = '0;
            act_n  = ACT_RESET;
        end else if (irq_set != '0) begin
            act_n  = ACT_IRQ;
        end
        wake_n = (pm_e'(pwr_mode) == PM_SLEEP) && (act_n != ACT_NONE);

        state_n = state_q;
        unique case (state_q)
            ST_IDLE, ST_IRQ, ST_RESET: begin
                if (rst_hit)             state_n = ST_RESET;
                else if (pend_n != '0)   state_n = ST_IRQ;
                else                     state_n = ST_IDLE;
            end
            default:                     state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            act_q   <= ACT_NONE;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            pend_q  <= pend_n;
            act_q   <= act_n;
            wake_q  <= wake_n;
        end
    end

    // Outputs by state
    always_comb begin
        irq_req = 1'b0;
        rst_req = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_IRQ:   irq_req = 1'b1;
            ST_RESET: rst_req = 1'b1;
            default:  ;
        endcase
    end

    assign pend     = pend_q;
    assign act_code = act_q;
    assign wake     = wake_q;

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_req, rst_req})); // R8

    AST_WDT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_to |=> (rst_req && act_code == 2'b10)); // R4

    AST_RESTART_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (pend == '0)); // R8

    AST_SLEEP_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'b00) |=> ((pend & ~$past(pend)) == '0)); // R3

    AST_WAKE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (rst_req && $past(pwr_mode) == 2'b00)); // R10

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req |-> (irq_req == (pend != '0))); // R11

endmodule

// File: tb/tb_pwr_event_arbiter.sv
module tb_pwr_event_arbiter;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] pwr_mode;
    logic       gie;
    logic [2:0] tmr_en;
    logic [2:0] port_en;
    logic       dd_en, ovf_en, dd_edge_rise;
    logic [2:0] tmr_to;
    logic       wdt_to;
    logic [3:0] port_pin;
    logic       dd_pin, stk_ovf;
    logic [5:0] pend_clr;
    logic [5:0] pend;
    logic       irq_req, rst_req, wake;
    logic [1:0] act_code;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pwr_event_arbiter dut (
        .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .gie(gie),
        .tmr_en(tmr_en), .port_en(port_en), .dd_en(dd_en), .ovf_en(ovf_en),
        .dd_edge_rise(dd_edge_rise), .tmr_to(tmr_to), .wdt_to(wdt_to),
        .port_pin(port_pin), .dd_pin(dd_pin), .stk_ovf(stk_ovf),
        .pend_clr(pend_clr), .pend(pend), .irq_req(irq_req),
        .rst_req(rst_req), .act_code(act_code), .wake(wake)
    );

    task automatic chk(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic hw_reset(input logic [1:0] m, input logic g);
        @(negedge clk);
        rst_n = 1'b0;
        pwr_mode = m; gie = g;
        tmr_en = '0; port_en = '0; dd_en = 0; ovf_en = 0; dd_edge_rise = 1'b1;
        tmr_to = '0; wdt_to = 0; stk_ovf = 0; pend_clr = '0;
        port_pin = 4'hF; dd_pin = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Sweep trial: src 0..2 timers, 3 port, 4 data-detect, 5 overflow, 6 watchdog
    task automatic trial(input int m, input int g, input int en, input int src);
        int exp_act, exp_pend, exp_wake;
        bit asleep;
        asleep = (m == 0);
        hw_reset(m[1:0], g[0]);
        @(negedge clk);
        if (en != 0) begin
            if (src < 3) tmr_en[src] = 1'b1;
            if (src == 3) port_en = 3'b001 << m;
            if (src == 4) dd_en = 1'b1;
            if (src == 5) ovf_en = 1'b1;
        end
        exp_act = 0; exp_pend = 0;
        if (src == 6) exp_act = 2;
        else if (src == 3) begin
            if (g != 0 && en != 0) begin
                if (asleep) exp_act = 2;
                else begin exp_act = 1; exp_pend = 8; end
            end
        end else if (!asleep && g != 0 && en != 0) begin
            exp_act = 1; exp_pend = 1 << src;
        end
        exp_wake = (asleep && exp_act != 0) ? 1 : 0;

        if (src < 3) begin tmr_to[src] = 1'b1; tick(); end
        else if (src == 3) begin port_pin[0] = 1'b0; repeat (3) @(posedge clk); #1; end
        else if (src == 4) begin dd_pin = 1'b1; repeat (3) @(posedge clk); #1; end
        else if (src == 5) begin stk_ovf = 1'b1; tick(); end
        else begin wdt_to = 1'b1; tick(); end

        // R2 R3 R4 R5 R6 R7: action and pending per mode/enable
        chk($sformatf("R2/R3/R4/R5 act m=%0d g=%0d en=%0d src=%0d", m, g, en, src),
            act_code, exp_act);
        chk($sformatf("R3/R7 pend m=%0d g=%0d en=%0d src=%0d", m, g, en, src),
            pend, exp_pend);
        chk($sformatf("R4 rst_req src=%0d", src), rst_req, (exp_act == 2) ? 1 : 0);
        chk($sformatf("R10 wake m=%0d src=%0d", m, src), wake, exp_wake);
        @(negedge clk);
        tmr_to = '0; wdt_to = 0; stk_ovf = 0;
        #1;
        if (exp_wake != 0) begin
            @(posedge clk); #1;
            chk("R10 wake one cycle", wake, 0);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        hw_reset(2'b10, 1'b1);
        rst_n = 1'b0;
        tick();
        // R1 reset state
        chk("R1 pend", pend, 0);
        chk("R1 irq_req", irq_req, 0);
        chk("R1 rst_req", rst_req, 0);
        chk("R1 act_code", act_code, 0);
        chk("R1 wake", wake, 0);
        @(negedge clk); rst_n = 1'b1;
        tick();
        chk("R1 first cycle pend", pend, 0);

        for (int m = 0; m < 3; m++)
            for (int g = 0; g < 2; g++)
                for (int en = 0; en < 2; en++)
                    for (int src = 0; src < 7; src++)
                        trial(m, g, en, src);

        // R5: rising edge ignored, falling on pin 3 accepted
        hw_reset(2'b01, 1'b1);
        @(negedge clk); port_en = 3'b100; port_pin = 4'h7;
        repeat (4) @(posedge clk); #1;
        @(negedge clk); port_pin = 4'hF;
        repeat (4) @(posedge clk); #1;
        chk("R5 rising edge ignored", pend, 8);
        chk("R5 irq held", irq_req, 1);

        // R6: falling-edge selection, rising edge ignored
        hw_reset(2'b10, 1'b1);
        @(negedge clk); dd_en = 1'b1; dd_edge_rise = 1'b0; dd_pin = 1'b1;
        repeat (4) @(posedge clk); #1;
        chk("R6 unselected rising edge", pend, 0);
        @(negedge clk); dd_pin = 1'b0;
        repeat (3) @(posedge clk); #1;
        chk("R6 selected falling edge", pend, 16);
        chk("R6 act", act_code, 1);

        // R8: restart beats interrupt in the same cycle
        hw_reset(2'b10, 1'b1);
        @(negedge clk); tmr_en = 3'b111; tmr_to = 3'b001; tick();
        @(negedge clk); tmr_to = 3'b010; wdt_to = 1'b1; tick();
        chk("R8 act restart", act_code, 2);
        chk("R8 pend cleared", pend, 0);
        chk("R8 irq low", irq_req, 0);
        @(negedge clk); tmr_to = '0; wdt_to = 0;

        // R9 R11: write-one-to-clear and request release
        hw_reset(2'b01, 1'b1);
        @(negedge clk); tmr_en = 3'b111; tmr_to = 3'b011; tick();
        chk("R11 irq with pend", irq_req, 1);
        @(negedge clk); tmr_to = '0; pend_clr = 6'b000001; tick();
        chk("R9 clear bit0", pend, 2);
        chk("R11 irq still high", irq_req, 1);
        @(negedge clk); pend_clr = 6'b000010; tmr_to = 3'b010; tick();
        chk("R9 set beats clear", pend, 2);
        @(negedge clk); tmr_to = '0; pend_clr = 6'b000010; tick();
        chk("R9 last cleared", pend, 0);
        chk("R11 irq drops with last flag", irq_req, 0);
        @(negedge clk); pend_clr = '0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule